// File: doc/BRIEF.md
# Page-Bounded Virtually-Indexed Physically-Tagged Data Cache

This block is a direct-mapped data cache whose total capacity fits inside one page. The line index and the byte-within-line offset therefore come entirely from the page-offset field. That field is the same in a virtual address and the physical address it maps to. The cache can start reading its tag and data arrays in the cycle a request arrives, using the virtual address. In that same cycle it sends the virtual page number to an external translation unit. When the physical page number comes back, the cache compares it with the physical page number stored as the line's tag.

Two virtual pages can map to one physical page. Both resolve to the same line, because the index does not depend on the page number. Two further rules keep aliasing harmless. Every store goes straight to memory, and the cache never allocates a line on a store. A context-switch strobe clears every valid bit in a single cycle. A refill fetches the line word by word over a simple request/acknowledge memory port. A translation fault ends the access with an error flag and changes nothing.

A configuration whose index and line-offset bits do not fit inside the page offset stops elaboration with an error.

Top module: `vipt_cache`

## Requirements
- R1: After reset no line is valid, `cpu_req_ready` is 1, and `cpu_rsp_valid` and `mem_req_valid` are 0. The first load to any address misses.
- R2: A request is accepted in a cycle where `cpu_req_valid` and `cpu_req_ready` are both 1. In that same cycle `tr_req_valid` is 1 and `tr_req_vpn` equals vaddr[31:12]. `cpu_req_ready` stays 0 from the next cycle until the response.
- R3: On a load hit, `cpu_rsp_valid` is 1 for one cycle, in the cycle after `tr_rsp_valid`. It carries the word at vaddr[11:2], with `cpu_rsp_err` at 0, and no memory request is made.
- R4: On a load miss, the cache issues eight word reads, one at a time, to {ppn, vaddr[11:5], k, 2'b00} for k = 0 to 7 in ascending order. The response comes in the cycle after the eighth acknowledge and carries the requested word. A later load to that line with the same ppn hits.
- R5: A hit requires a valid line whose stored tag equals the translated ppn. A different virtual page that maps to the same ppn hits. The same virtual address with a different ppn misses.
- R6: A store whose translation does not fault issues exactly one memory write to {ppn, vaddr[11:2], 2'b00} with the store data. It responds in the cycle after the acknowledge. On a hit, the cached word is also updated, so a later load returns the new value without a refill.
- R7: A store miss does not allocate: a later load to that line still misses and returns the stored value from memory.
- R8: When `tr_rsp_fault` is 1, the cache responds in the next cycle with `cpu_rsp_err` at 1. It makes no memory request and leaves the arrays unchanged. A faulting store to a cached word leaves the old data visible as a hit.
- R9: A one-cycle `ctx_inval` pulse clears every valid bit, so the next load to any line misses.
- R10: While `mem_req_valid` is 1 and `mem_ack` is 0, the memory request address, direction and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_vaddr | input | 32 | Virtual byte address (word aligned) |
| cpu_req_wdata | input | 32 | Store data |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_rsp_valid | output | 1 | One-cycle response strobe |
| cpu_rsp_data | output | 32 | Load data |
| cpu_rsp_err | output | 1 | Translation fault |
| tr_req_valid | output | 1 | Translation request |
| tr_req_vpn | output | 20 | Virtual page number |
| tr_rsp_valid | input | 1 | Translation result present |
| tr_rsp_ppn | input | 20 | Physical page number |
| tr_rsp_fault | input | 1 | Translation failed |
| mem_req_valid | output | 1 | Memory request held until acknowledged |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Physical byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| ctx_inval | input | 1 | Invalidate all lines |

## Verification
The embedded properties check four rules on every cycle. The memory request stays stable while it waits. Ready drops right after a translation request. Every response follows a translation result or a memory acknowledge, and a faulting response follows a fault. An invalidate pulse leaves no valid bit set. Only the bench scenarios can show the rest. These include data correctness, the refill address order, hit or miss under virtual aliases and conflicting physical tags, the absence of allocation on a store miss, and the behaviour of stores that fault. The bench uses a shadow tag table and a memory model to check them.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    localparam int unsigned DEF_PAGE_BYTES = 4096;
    localparam int unsigned DEF_LINE_BYTES = 32;
    localparam int unsigned DEF_NUM_LINES  = 128;
    localparam int unsigned DEF_WORD_BYTES = 4;
    localparam int unsigned DEF_ADDR_BITS  = 32;

    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_XLATE = 2'd1,
        CS_FILL  = 2'd2,
        CS_WRITE = 2'd3
    } cache_st_e;

    // Index and line-offset bits must sit inside the page offset.
    function automatic bit fits_in_page(int unsigned page_b, int unsigned line_b,
                                        int unsigned lines);
        return (line_b * lines) <= page_b;
    endfunction

endpackage

// File: rtl/vc_tag_store.sv
module vc_tag_store #(
    parameter int unsigned IDX_W = 7,
    parameter int unsigned TAG_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inval,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    output logic             rd_vld,
    output logic [TAG_W-1:0] rd_tag
);
    localparam int unsigned ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] vld_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst || inval) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !inval) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || inval) begin
            rd_vld <= 1'b0;
            rd_tag <= '0;
        end else if (rd_en) begin
            rd_vld <= vld_q[rd_idx];
            rd_tag <= tag_q[rd_idx];
        end
    end

    // R9
    inval_clear_chk: assert property (@(posedge clk) disable iff (rst)
        inval |=> (vld_q == '0));

endmodule

// File: rtl/vc_data_store.sv
module vc_data_store #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= mem_q[rd_addr];
        end
    end

endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl
    import vipt_pkg::*;
#(
    parameter int unsigned VA_BITS = 32,
    parameter int unsigned PA_BITS = 32,
    parameter int unsigned PG_OFF  = 12,
    parameter int unsigned LN_OFF  = 5,
    parameter int unsigned WB      = 2,
    parameter int unsigned IDX_W   = 7,
    parameter int unsigned DW      = 32,
    localparam int unsigned WSEL_W = LN_OFF - WB,
    localparam int unsigned VPN_W  = VA_BITS - PG_OFF,
    localparam int unsigned PPN_W  = PA_BITS - PG_OFF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cpu_req_valid,
    input  logic                    cpu_req_we,
    input  logic [VA_BITS-1:0]      cpu_req_vaddr,
    input  logic [DW-1:0]           cpu_req_wdata,
    output logic                    cpu_req_ready,
    output logic                    cpu_rsp_valid,
    output logic [DW-1:0]           cpu_rsp_data,
    output logic                    cpu_rsp_err,
    output logic                    tr_req_valid,
    output logic [VPN_W-1:0]        tr_req_vpn,
    input  logic                    tr_rsp_valid,
    input  logic [PPN_W-1:0]        tr_rsp_ppn,
    input  logic                    tr_rsp_fault,
    output logic                    mem_req_valid,
    output logic                    mem_req_we,
    output logic [PA_BITS-1:0]      mem_req_addr,
    output logic [DW-1:0]           mem_req_wdata,
    input  logic                    mem_ack,
    input  logic [DW-1:0]           mem_rdata,
    input  logic                    ctx_inval,
    // array side
    output logic                    tag_rd_en,
    output logic [IDX_W-1:0]        tag_rd_idx,
    output logic                    tag_wr_en,
    output logic [IDX_W-1:0]        tag_wr_idx,
    output logic [PPN_W-1:0]        tag_wr_tag,
    input  logic                    tag_rd_vld,
    input  logic [PPN_W-1:0]        tag_rd_tag,
    output logic                    dat_rd_en,
    output logic [IDX_W+WSEL_W-1:0] dat_rd_addr,
    output logic                    dat_wr_en,
    output logic [IDX_W+WSEL_W-1:0] dat_wr_addr,
    output logic [DW-1:0]           dat_wr_data,
    input  logic [DW-1:0]           dat_rd_data
);
    cache_st_e          st_q;
    logic               we_q;
    logic [PG_OFF-1:0]  off_q;
    logic [DW-1:0]      wdata_q;
    logic [PPN_W-1:0]   ppn_q;
    logic [WSEL_W-1:0]  cnt_q;
    logic               rsp_v_q;
    logic               rsp_err_q;
    logic [DW-1:0]      rsp_data_q;

    logic               accept;
    logic               hit;
    logic               xl_done;
    logic               fill_last;
    logic [IDX_W-1:0]   idx_q;
    logic [WSEL_W-1:0]  wsel_q;

    assign idx_q  = off_q[LN_OFF +: IDX_W];
    assign wsel_q = off_q[WB +: WSEL_W];

    assign cpu_req_ready = (st_q == CS_IDLE) && !ctx_inval;
    assign accept        = cpu_req_ready && cpu_req_valid;

    // Lookup and translation start together; index is page-offset only.
    assign tr_req_valid = accept;
    assign tr_req_vpn   = cpu_req_vaddr[VA_BITS-1:PG_OFF];
    assign tag_rd_en    = accept;
    assign tag_rd_idx   = cpu_req_vaddr[LN_OFF +: IDX_W];
    assign dat_rd_en    = accept;
    assign dat_rd_addr  = cpu_req_vaddr[WB +: IDX_W+WSEL_W];

    assign xl_done   = (st_q == CS_XLATE) && tr_rsp_valid;
    assign hit       = tag_rd_vld && (tag_rd_tag == tr_rsp_ppn);
    assign fill_last = (st_q == CS_FILL) && mem_ack && (cnt_q == {WSEL_W{1'b1}});

    assign mem_req_valid = (st_q == CS_FILL) || (st_q == CS_WRITE);
    assign mem_req_we    = (st_q == CS_WRITE);
    assign mem_req_wdata = wdata_q;
    always_comb begin
        if (st_q == CS_WRITE) begin
            mem_req_addr = {ppn_q, off_q[PG_OFF-1:WB], {WB{1'b0}}};
        end else begin
            mem_req_addr = {ppn_q, off_q[PG_OFF-1:LN_OFF], cnt_q, {WB{1'b0}}};
        end
    end

    always_comb begin
        dat_wr_en   = 1'b0;
        dat_wr_addr = {idx_q, wsel_q};
        dat_wr_data = wdata_q;
        if (xl_done && !tr_rsp_fault && we_q && hit) begin
            dat_wr_en = 1'b1;
        end else if ((st_q == CS_FILL) && mem_ack) begin
            dat_wr_en   = 1'b1;
            dat_wr_addr = {idx_q, cnt_q};
            dat_wr_data = mem_rdata;
        end
    end

    assign tag_wr_en  = fill_last;
    assign tag_wr_idx = idx_q;
    assign tag_wr_tag = ppn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= CS_IDLE;
            we_q       <= 1'b0;
            off_q      <= '0;
            wdata_q    <= '0;
            ppn_q      <= '0;
            cnt_q      <= '0;
            rsp_v_q    <= 1'b0;
            rsp_err_q  <= 1'b0;
            rsp_data_q <= '0;
        end else begin
            rsp_v_q <= 1'b0;
            unique case (st_q)
                CS_IDLE: if (accept) begin
                    we_q    <= cpu_req_we;
                    off_q   <= cpu_req_vaddr[PG_OFF-1:0];
                    wdata_q <= cpu_req_wdata;
                    st_q    <= CS_XLATE;
                end
                CS_XLATE: if (tr_rsp_valid) begin
                    ppn_q <= tr_rsp_ppn;
                    cnt_q <= '0;
                    if (tr_rsp_fault) begin
                        rsp_v_q   <= 1'b1;
                        rsp_err_q <= 1'b1;
                        st_q      <= CS_IDLE;
                    end else if (we_q) begin
                        st_q <= CS_WRITE;
                    end else if (hit) begin
                        rsp_v_q    <= 1'b1;
                        rsp_err_q  <= 1'b0;
                        rsp_data_q <= dat_rd_data;
                        st_q       <= CS_IDLE;
                    end else begin
                        st_q <= CS_FILL;
                    end
                end
                CS_FILL: if (mem_ack) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == wsel_q) begin
                        rsp_data_q <= mem_rdata;
                    end
                    if (fill_last) begin
                        rsp_v_q   <= 1'b1;
                        rsp_err_q <= 1'b0;
                        st_q      <= CS_IDLE;
                    end
                end
                CS_WRITE: if (mem_ack) begin
                    rsp_v_q   <= 1'b1;
                    rsp_err_q <= 1'b0;
                    st_q      <= CS_IDLE;
                end
                default: st_q <= CS_IDLE;
            endcase
        end
    end

    assign cpu_rsp_valid = rsp_v_q;
    assign cpu_rsp_err   = rsp_err_q;
    assign cpu_rsp_data  = rsp_data_q;

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_ack) |=> (mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_we) && $stable(mem_req_wdata)));

    // R2
    busy_after_lookup_chk: assert property (@(posedge clk) disable iff (rst)
        tr_req_valid |=> !cpu_req_ready);

    // R3
    rsp_source_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_rsp_valid |-> $past(tr_rsp_valid || mem_ack));

    // R8
    fault_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_rsp_valid && cpu_rsp_err) |-> $past(tr_rsp_valid && tr_rsp_fault && !mem_req_valid));

endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
    import vipt_pkg::*;
#(
    parameter int unsigned PAGE_BYTES = DEF_PAGE_BYTES,
    parameter int unsigned LINE_BYTES = DEF_LINE_BYTES,
    parameter int unsigned NUM_LINES  = DEF_NUM_LINES,
    parameter int unsigned WORD_BYTES = DEF_WORD_BYTES,
    parameter int unsigned VA_BITS    = DEF_ADDR_BITS,
    parameter int unsigned PA_BITS    = DEF_ADDR_BITS,
    localparam int unsigned PG_OFF = $clog2(PAGE_BYTES),
    localparam int unsigned LN_OFF = $clog2(LINE_BYTES),
    localparam int unsigned WB     = $clog2(WORD_BYTES),
    localparam int unsigned IDX_W  = $clog2(NUM_LINES),
    localparam int unsigned WSEL_W = LN_OFF - WB,
    localparam int unsigned DW     = 8 * WORD_BYTES,
    localparam int unsigned VPN_W  = VA_BITS - PG_OFF,
    localparam int unsigned PPN_W  = PA_BITS - PG_OFF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_req_valid,
    input  logic               cpu_req_we,
    input  logic [VA_BITS-1:0] cpu_req_vaddr,
    input  logic [DW-1:0]      cpu_req_wdata,
    output logic               cpu_req_ready,
    output logic               cpu_rsp_valid,
    output logic [DW-1:0]      cpu_rsp_data,
    output logic               cpu_rsp_err,
    output logic               tr_req_valid,
    output logic [VPN_W-1:0]   tr_req_vpn,
    input  logic               tr_rsp_valid,
    input  logic [PPN_W-1:0]   tr_rsp_ppn,
    input  logic               tr_rsp_fault,
    output logic               mem_req_valid,
    output logic               mem_req_we,
    output logic [PA_BITS-1:0] mem_req_addr,
    output logic [DW-1:0]      mem_req_wdata,
    input  logic               mem_ack,
    input  logic [DW-1:0]      mem_rdata,
    input  logic               ctx_inval
);
    generate
        if (!fits_in_page(PAGE_BYTES, LINE_BYTES, NUM_LINES)
            || (IDX_W + LN_OFF > PG_OFF)) begin : g_bad_geometry
            $error("vipt_cache: cache way larger than one page");
        end
    endgenerate

    logic                    tag_rd_en, tag_wr_en, tag_rd_vld;
    logic [IDX_W-1:0]        tag_rd_idx, tag_wr_idx;
    logic [PPN_W-1:0]        tag_wr_tag, tag_rd_tag;
    logic                    dat_rd_en, dat_wr_en;
    logic [IDX_W+WSEL_W-1:0] dat_rd_addr, dat_wr_addr;
    logic [DW-1:0]           dat_wr_data, dat_rd_data;

    vc_ctrl #(
        .VA_BITS(VA_BITS), .PA_BITS(PA_BITS), .PG_OFF(PG_OFF), .LN_OFF(LN_OFF),
        .WB(WB), .IDX_W(IDX_W), .DW(DW)
    ) u_ctrl (
        .clk, .rst,
        .cpu_req_valid, .cpu_req_we, .cpu_req_vaddr, .cpu_req_wdata, .cpu_req_ready,
        .cpu_rsp_valid, .cpu_rsp_data, .cpu_rsp_err,
        .tr_req_valid, .tr_req_vpn, .tr_rsp_valid, .tr_rsp_ppn, .tr_rsp_fault,
        .mem_req_valid, .mem_req_we, .mem_req_addr, .mem_req_wdata, .mem_ack, .mem_rdata,
        .ctx_inval,
        .tag_rd_en, .tag_rd_idx, .tag_wr_en, .tag_wr_idx, .tag_wr_tag,
        .tag_rd_vld, .tag_rd_tag,
        .dat_rd_en, .dat_rd_addr, .dat_wr_en, .dat_wr_addr, .dat_wr_data, .dat_rd_data
    );

    vc_tag_store #(.IDX_W(IDX_W), .TAG_W(PPN_W)) u_tags (
        .clk, .rst, .inval(ctx_inval),
        .rd_en(tag_rd_en), .rd_idx(tag_rd_idx),
        .wr_en(tag_wr_en), .wr_idx(tag_wr_idx), .wr_tag(tag_wr_tag),
        .rd_vld(tag_rd_vld), .rd_tag(tag_rd_tag)
    );

    vc_data_store #(.ADDR_W(IDX_W + WSEL_W), .DATA_W(DW)) u_data (
        .clk,
        .rd_en(dat_rd_en), .rd_addr(dat_rd_addr),
        .wr_en(dat_wr_en), .wr_addr(dat_wr_addr), .wr_data(dat_wr_data),
        .rd_data(dat_rd_data)
    );

endmodule

// File: tb/sim_vipt_cache.sv
module sim_vipt_cache;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req_valid = 1'b0, cpu_req_we = 1'b0;
    logic [31:0] cpu_req_vaddr = '0, cpu_req_wdata = '0;
    logic        cpu_req_ready, cpu_rsp_valid, cpu_rsp_err;
    logic [31:0] cpu_rsp_data;
    logic        tr_req_valid;
    logic [19:0] tr_req_vpn;
    logic        tr_rsp_valid = 1'b0, tr_rsp_fault = 1'b0;
    logic [19:0] tr_rsp_ppn = '0;
    logic        mem_req_valid, mem_req_we;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        ctx_inval = 1'b0;

    vipt_cache u0 (.*);

    always #2.5 clk = ~clk;   // 200 MHz

    int total = 0, bad = 0, cyc = 0, last_ack_cyc = -10;
    bit finished = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // memory model, read/write logs
    logic [31:0] mem_m [logic [31:0]];
    logic [31:0] rd_log [16];
    int          rd_n = 0, wr_n = 0;
    logic [31:0] wr_addr_l, wr_data_l;
    bit          sh_v [128];
    logic [19:0] sh_t [128];

    function automatic logic [31:0] mem_val(logic [31:0] pa);
        if (mem_m.exists(pa)) return mem_m[pa];
        return (pa * 32'h9E3779B1) ^ 32'h0BAD_F00D;
    endfunction

    function automatic logic [19:0] ppn_of(logic [19:0] vpn);
        return (vpn >> 1) ^ 20'h003C1;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // memory responder with random wait states; checks R10 on every waiting cycle
    initial begin
        int          wcnt = 0;
        bit          pend = 0;
        logic [31:0] h_addr = '0, h_data = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                pend = 0;
            end else if (mem_req_valid && !rst) begin
                if (pend) begin
                    // R10 request held stable while unacknowledged
                    chk(mem_req_addr == h_addr && mem_req_wdata == h_data, "R10 hold",
                        mem_req_addr, h_addr);
                end
                pend = 1; h_addr = mem_req_addr; h_data = mem_req_wdata;
                if (wcnt > 0) begin
                    wcnt--;
                end else begin
                    mem_ack = 1'b1;
                    last_ack_cyc = cyc;
                    if (mem_req_we) begin
                        mem_m[mem_req_addr] = mem_req_wdata;
                        wr_addr_l = mem_req_addr; wr_data_l = mem_req_wdata;
                        wr_n++;
                    end else begin
                        mem_rdata = mem_val(mem_req_addr);
                        if (rd_n < 16) rd_log[rd_n] = mem_req_addr;
                        rd_n++;
                    end
                    wcnt = $urandom % 3;
                end
            end
        end
    end

    task automatic access(bit we, logic [31:0] va, logic [31:0] wd,
                          logic [19:0] ppn, bit fault, int lat);
        logic [6:0]  idx = va[11:5];
        logic [31:0] pa = {ppn, va[11:2], 2'b00};
        bit          hit = !fault && sh_v[idx] && sh_t[idx] == ppn;
        bit          quick = fault || (!we && hit);
        logic [31:0] exp_d = mem_val(pa);
        bit          got = 0;
        @(negedge clk);
        rd_n = 0; wr_n = 0;
        cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_vaddr = va; cpu_req_wdata = wd;
        #1;
        // R2 lookup and translation in acceptance cycle
        chk(cpu_req_ready && tr_req_valid, "R2 accept", {30'd0, cpu_req_ready, tr_req_valid}, 32'd3);
        chk(tr_req_vpn == va[31:12], "R2 vpn", {12'd0, tr_req_vpn}, {12'd0, va[31:12]});
        @(negedge clk);
        cpu_req_valid = 1'b0;
        #1;
        chk(!cpu_req_ready, "R2 busy", {31'd0, cpu_req_ready}, 32'd0);
        repeat (lat) @(negedge clk);
        tr_rsp_valid = 1'b1; tr_rsp_ppn = ppn; tr_rsp_fault = fault;
        @(negedge clk);
        tr_rsp_valid = 1'b0; tr_rsp_fault = 1'b0;
        #1;
        if (quick) begin
            // R3 / R8 response one cycle after translation
            chk(cpu_rsp_valid, fault ? "R8 rsp timing" : "R3 hit timing",
                {31'd0, cpu_rsp_valid}, 32'd1);
            got = cpu_rsp_valid;
        end else begin
            for (int k = 0; k < 300; k++) begin
                if (cpu_rsp_valid) begin got = 1; break; end
                @(negedge clk); #1;
            end
            chk(got, "R4 response seen", {31'd0, got}, 32'd1);
            chk(cyc == last_ack_cyc + 1, we ? "R6 rsp after ack" : "R4 rsp after last ack",
                cyc, last_ack_cyc + 1);
        end
        if (got) begin
            chk(cpu_rsp_err == fault, "R8 err flag", {31'd0, cpu_rsp_err}, {31'd0, fault});
            if (!we && !fault)
                chk(cpu_rsp_data == exp_d, hit ? "R3 hit data" : "R4 miss data",
                    cpu_rsp_data, exp_d);
        end
        chk(rd_n == ((!we && !fault && !hit) ? 8 : 0), hit ? "R5 hit no reads" : "R4 read count",
            rd_n, (!we && !fault && !hit) ? 8 : 0);
        chk(wr_n == ((we && !fault) ? 1 : 0), fault ? "R8 no write" : "R6 write count",
            wr_n, (we && !fault) ? 1 : 0);
        if (!we && !fault && !hit && rd_n == 8) begin
            for (int k = 0; k < 8; k++) begin
                logic [31:0] ea = {ppn, va[11:5], k[2:0], 2'b00};
                chk(rd_log[k] == ea, "R4 refill order", rd_log[k], ea);
            end
        end
        if (we && !fault && wr_n == 1) begin
            chk(wr_addr_l == pa && wr_data_l == wd, "R6 write addr/data", wr_addr_l, pa);
        end
        if (!we && !fault && !hit) begin
            sh_v[idx] = 1; sh_t[idx] = ppn;
        end
    endtask

    task automatic acc(bit we, logic [31:0] va, logic [31:0] wd);
        access(we, va, wd, ppn_of(va[31:12]), 1'b0, $urandom % 3);
    endtask

    task automatic inval();
        @(negedge clk); ctx_inval = 1'b1;
        @(negedge clk); ctx_inval = 1'b0;
        for (int i = 0; i < 128; i++) sh_v[i] = 0;
    endtask

    initial begin
        void'($urandom(32'd1337));
        for (int i = 0; i < 128; i++) begin sh_v[i] = 0; sh_t[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R1 reset state
        chk(cpu_req_ready && !cpu_rsp_valid && !mem_req_valid, "R1 reset outputs",
            {29'd0, cpu_req_ready, cpu_rsp_valid, mem_req_valid}, 32'd4);
        acc(0, 32'h0000_1044, 0);                 // R1 first load misses, R4 refill
        acc(0, 32'h0000_1044, 0);                 // R3 hit
        acc(0, 32'h0000_105C, 0);                 // R3 other word in line
        acc(0, 32'h0000_0048, 0);                 // R5 alias vpn 0 -> same ppn hits
        access(0, 32'h0000_1044, 0, 20'h00ABC, 0, 1); // R5 same va, other ppn misses
        acc(0, 32'h0000_1044, 0);                 // refill back
        acc(1, 32'h0000_1048, 32'hCAFE_0001);     // R6 store hit
        acc(0, 32'h0000_0048, 0);                 // R6 alias load sees new data as hit
        acc(1, 32'h0000_2200, 32'h1234_5678);     // R7 store miss
        acc(0, 32'h0000_2200, 0);                 // R7 must miss and see data
        access(0, 32'h0000_3300, 0, ppn_of(20'h3), 1, 0); // R8 fault load
        acc(0, 32'h0000_3300, 0);                 // R8 line untouched -> miss
        access(1, 32'h0000_3300, 32'hDEAD_BEEF, ppn_of(20'h3), 1, 2); // R8 fault store
        acc(0, 32'h0000_3300, 0);                 // R8 old data, still hit
        inval();                                  // R9
        acc(0, 32'h0000_1044, 0);                 // R9 miss after invalidate
        acc(0, 32'h0000_3300, 0);                 // R9 miss after invalidate
        for (int n = 0; n < 400; n++) begin
            logic [31:0] va;
            va = {12'd0, 8'd0 + 8'($urandom % 6), 3'($urandom % 4), 4'd0, 3'($urandom % 8), 2'b00};
            if ($urandom % 40 == 0) inval();
            access($urandom % 3 == 0, va, $urandom, ppn_of(va[31:12]),
                   $urandom % 16 == 0, $urandom % 3);
        end
        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=0", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule